// File: doc/BRIEF.md
# Circular Delay-Buffer Address Mapper

This block turns the memory requests of a fixed-program audio DSP into physical addresses for an 18-bit-addressed delay-line memory of 0x40000 samples. A host loads eight mapping registers. Each one carves out a sub-buffer from a base (an 8-bit coarse base scaled by 1024) and a power-of-two length (1024 shifted left by a 3-bit size code). Each access-capable instruction supplies a 16-bit offset. The offset is added to a position counter that advances once per sample. The sum is masked to the sub-buffer length and added to the base. As the position counter moves, every delay line rotates through its own region of the memory without any software intervention. Bases need not be aligned to the sub-buffer length.

The block also tracks where the DSP is in its program. A program counter runs through 384 steps per output sample, one step for each accepted step strobe. An access may only start on a step whose counter value is a multiple of three. The word read from memory is handed back to the DSP together with the step two positions after the one that issued the access. The memory is expected to return its word in the clock cycle after the request.

Top module: `ring_addr_mapper`

## Requirements
- R1: After reset, all eight mapping registers read 0, `step_pc` and `sample_pos` are 0, and `mem_req` and `rd_valid` are low while no step is presented.
- R2: A host write with `cfg_we` high stores all 16 bits of `cfg_wdata` into register `cfg_wsel` at the clock edge. From the next cycle, `cfg_rdata` shows that value whenever `cfg_rsel` selects the register.
- R3: For an issued access, `mem_addr` = ((o << 10) + ((offset + sample_pos) & ((1 << (10 + s)) - 1))) mod 2^18. Here s is bits 10:8 and o is bits 7:0 of the mapping register chosen by `step_map`, and offset is `step_ofs`.
- R4: Bases not aligned to the sub-buffer length are used as given. A sum that passes 0x3FFFF wraps to the start of memory (for example, base 0x3FC00 with size code 7).
- R5: `mem_req` is high in the same cycle as an accepted step (`step_valid` high) whose `step_pc` is a multiple of 3 and whose `step_acc` is high. It is low in every other cycle, so `step_acc` on other steps is ignored.
- R6: `step_pc` advances by one for each accepted step and returns from 383 to 0. `sample_pos` advances by one on that return. Both hold while `step_valid` is low.
- R7: `rd_valid` is high together with the accepted step whose `step_pc` equals the issuing step's `step_pc` plus 2. At that point `rd_data` carries the word on `mem_rdata` in the cycle after the request.
- R8: Bits 15:11 of a mapping register are stored and read back but have no effect on `mem_addr`. A register write is used for addressing from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for a mapping register |
| cfg_wsel | input | 3 | Mapping register written |
| cfg_wdata | input | 16 | Written value: tag 15:11, size code 10:8, coarse base 7:0 |
| cfg_rsel | input | 3 | Mapping register read back |
| cfg_rdata | output | 16 | Read-back value of the selected register |
| step_valid | input | 1 | One program step is accepted this cycle |
| step_acc | input | 1 | The step asks for a memory access |
| step_map | input | 3 | Mapping register used by the access |
| step_ofs | input | 16 | Per-instruction offset |
| step_pc | output | 9 | Program position of the current step |
| sample_pos | output | 18 | Rotating sample position |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 18 | Physical memory address |
| mem_rdata | input | 16 | Memory word, valid the cycle after `mem_req` |
| rd_valid | output | 1 | Returned word delivered with this step |
| rd_data | output | 16 | Returned word |

## Verification
The bench sweeps every size code across all eight registers. Coarse bases vary from pass to pass, and twelve program passes advance the position counter. Offsets of all-ones, zero and scattered values separate the mask arithmetic from the base addition. Registers whose base plus length runs past the top of memory show whether the wrap is modulo 2^18. An aligned-versus-unaligned pair (base 0x28000, length 0x10000) shows that no alignment is imposed. Non-zero tag fields on alternate passes show whether the tag leaks into addressing. Steps are stalled at irregular points and `step_acc` is raised on non-issuing steps. Together these tell a correct three-step issue rule and two-step return lag apart from versions that count cycles instead of steps.

// File: rtl/rbam_pkg.sv
package rbam_pkg;

    // Field widths of one mapping register (tag | size code | coarse base).
    localparam int TAG_W  = 5;
    localparam int SZC_W  = 3;
    localparam int BASE_W = 8;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;    // kept for software, unused by addressing
        logic [SZC_W-1:0]  szc;    // length = 1 << (granule + szc)
        logic [BASE_W-1:0] basec;  // base   = basec << granule
    } map_cfg_t;

    localparam int CFG_W = $bits(map_cfg_t);

endpackage

// File: rtl/rbam_map_regs.sv
module rbam_map_regs
    import rbam_pkg::*;
#(
    parameter int NUM_MAPS = 8,
    parameter int SEL_W    = $clog2(NUM_MAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  map_cfg_t         wdata,
    input  logic [SEL_W-1:0] rsel,
    input  logic [SEL_W-1:0] lsel,
    output map_cfg_t         rcfg,
    output map_cfg_t         lcfg
);

    typedef struct packed {
        map_cfg_t [NUM_MAPS-1:0] regs;
    } st_t;

    st_t                 st_d, st_q;
    logic [NUM_MAPS-1:0] hit;

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_dec
        assign hit[g] = we && (wsel == SEL_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_MAPS; i++) begin
            if (hit[i]) begin
                st_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rcfg = st_q.regs[rsel];
    assign lcfg = st_q.regs[lsel];

endmodule

// File: rtl/rbam_seq.sv
module rbam_seq #(
    parameter int STEPS       = 384,
    parameter int ISSUE_EVERY = 3,
    parameter int POS_W       = 18,
    parameter int PC_W        = $clog2(STEPS),
    parameter int PH_W        = (ISSUE_EVERY > 1) ? $clog2(ISSUE_EVERY) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PC_W-1:0]  pc,
    output logic             slot_open,
    output logic [POS_W-1:0] pos
);

    localparam logic [PC_W-1:0] LAST_PC = PC_W'(STEPS - 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(ISSUE_EVERY - 1);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PH_W-1:0]  ph;
        logic [POS_W-1:0] pos;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.pc == LAST_PC) begin
                st_d.pc  = '0;
                st_d.ph  = '0;
                st_d.pos = st_q.pos + 1'b1;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
                st_d.ph = (st_q.ph == LAST_PH) ? '0 : st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc        = st_q.pc;
    assign slot_open = (st_q.ph == '0);
    assign pos       = st_q.pos;

endmodule

// File: rtl/rbam_addr_calc.sv
module rbam_addr_calc
    import rbam_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int OFS_W      = 16,
    parameter int POS_W      = 18,
    parameter int GRAN_SHIFT = 10
) (
    input  logic [SZC_W-1:0]  szc,
    input  logic [BASE_W-1:0] basec,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] rot_sum;
    logic [ADDR_W-1:0] base_addr;

    always_comb begin
        span_mask = (ADDR_W'(1) << (GRAN_SHIFT + 32'(szc))) - ADDR_W'(1);
        rot_sum   = ADDR_W'(ofs) + ADDR_W'(pos);
        base_addr = ADDR_W'(basec) << GRAN_SHIFT;
        addr      = base_addr + (rot_sum & span_mask);
    end

endmodule

// File: rtl/rbam_ret_track.sv
module rbam_ret_track #(
    parameter int PC_W    = 9,
    parameter int DATA_W  = 16,
    parameter int RET_LAG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              adv,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              pend;
        logic [PC_W-1:0]   due;
        logic              cap;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t  st_d, st_q;
    logic hand_back;

    assign hand_back = adv && st_q.pend && (pc == st_q.due);

    always_comb begin
        st_d     = st_q;
        st_d.cap = issue;
        if (st_q.cap) begin
            st_d.data = mem_rdata;
        end
        if (issue) begin
            st_d.pend = 1'b1;
            st_d.due  = pc + PC_W'(RET_LAG);
        end else if (hand_back) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = hand_back;
    assign rd_data  = st_q.data;

endmodule

// File: rtl/ring_addr_mapper.sv
module ring_addr_mapper
    import rbam_pkg::*;
#(
    parameter int NUM_MAPS    = 8,
    parameter int STEPS       = 384,
    parameter int ISSUE_EVERY = 3,
    parameter int RET_LAG     = 2,
    parameter int ADDR_W      = 18,
    parameter int OFS_W       = 16,
    parameter int DATA_W      = 16,
    parameter int POS_W       = 18,
    parameter int GRAN_SHIFT  = 10,
    localparam int SEL_W      = $clog2(NUM_MAPS),
    localparam int PC_W       = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_wsel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [SEL_W-1:0]  cfg_rsel,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              step_valid,
    input  logic              step_acc,
    input  logic [SEL_W-1:0]  step_map,
    input  logic [OFS_W-1:0]  step_ofs,
    output logic [PC_W-1:0]   step_pc,
    output logic [POS_W-1:0]  sample_pos,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    map_cfg_t rd_cfg;
    map_cfg_t use_cfg;
    logic     slot_open;

    rbam_map_regs #(
        .NUM_MAPS (NUM_MAPS),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_wsel),
        .wdata (map_cfg_t'(cfg_wdata)),
        .rsel  (cfg_rsel),
        .lsel  (step_map),
        .rcfg  (rd_cfg),
        .lcfg  (use_cfg)
    );

    rbam_seq #(
        .STEPS       (STEPS),
        .ISSUE_EVERY (ISSUE_EVERY),
        .POS_W       (POS_W),
        .PC_W        (PC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (step_valid),
        .pc        (step_pc),
        .slot_open (slot_open),
        .pos       (sample_pos)
    );

    rbam_addr_calc #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .POS_W      (POS_W),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) u_calc (
        .szc   (use_cfg.szc),
        .basec (use_cfg.basec),
        .ofs   (step_ofs),
        .pos   (sample_pos),
        .addr  (mem_addr)
    );

    assign mem_req   = step_valid && step_acc && slot_open;
    assign cfg_rdata = CFG_W'(rd_cfg);

    rbam_ret_track #(
        .PC_W    (PC_W),
        .DATA_W  (DATA_W),
        .RET_LAG (RET_LAG)
    ) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (mem_req),
        .adv       (step_valid),
        .pc        (step_pc),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/ring_addr_mapper_chk.sv
module ring_addr_mapper_chk #(
    parameter int STEPS       = 384,
    parameter int ISSUE_EVERY = 3,
    parameter int SEL_W       = 3,
    parameter int CFG_W       = 16,
    parameter int PC_W        = 9,
    parameter int POS_W       = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_wsel,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [SEL_W-1:0] cfg_rsel,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             step_valid,
    input logic             step_acc,
    input logic [PC_W-1:0]  step_pc,
    input logic [POS_W-1:0] sample_pos,
    input logic             mem_req,
    input logic             rd_valid
);

    localparam logic [PC_W-1:0] LAST_PC = PC_W'(STEPS - 1);

    // R5
    req_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (step_valid && step_acc));

    // R5
    req_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((32'(step_pc) % ISSUE_EVERY) == 0));

    // R6
    pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_pc != LAST_PC) |=>
        ((step_pc == $past(step_pc) + 1'b1) && $stable(sample_pos)));

    // R6
    pass_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_pc == LAST_PC) |=>
        ((step_pc == '0) && (sample_pos == $past(sample_pos) + 1'b1)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> ($stable(step_pc) && $stable(sample_pos)));

    // R7
    ret_with_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (step_valid && !mem_req));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wsel == cfg_rsel) |=>
        ((cfg_rsel != $past(cfg_rsel)) || (cfg_rdata == $past(cfg_wdata))));

endmodule

bind ring_addr_mapper ring_addr_mapper_chk #(
    .STEPS       (STEPS),
    .ISSUE_EVERY (ISSUE_EVERY),
    .SEL_W       (SEL_W),
    .CFG_W       (rbam_pkg::CFG_W),
    .PC_W        (PC_W),
    .POS_W       (POS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wsel   (cfg_wsel),
    .cfg_wdata  (cfg_wdata),
    .cfg_rsel   (cfg_rsel),
    .cfg_rdata  (cfg_rdata),
    .step_valid (step_valid),
    .step_acc   (step_acc),
    .step_pc    (step_pc),
    .sample_pos (sample_pos),
    .mem_req    (mem_req),
    .rd_valid   (rd_valid)
);

// File: tb/ring_addr_mapper_bench.sv
`timescale 1ns/1ps
module ring_addr_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wsel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  cfg_rsel = '0;
    logic [15:0] cfg_rdata;
    logic        step_valid = 1'b0;
    logic        step_acc = 1'b0;
    logic [2:0]  step_map = '0;
    logic [15:0] step_ofs = '0;
    logic [8:0]  step_pc;
    logic [17:0] sample_pos;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    ring_addr_mapper u_ring_addr_mapper (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .step_valid(step_valid), .step_acc(step_acc), .step_map(step_map),
        .step_ofs(step_ofs), .step_pc(step_pc), .sample_pos(sample_pos),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic int memf(input int a);
        return (a ^ (a >> 5) ^ (a >> 11) ^ 'h5A3) & 'hFFFF;
    endfunction

    // behavioural memory: word returned the cycle after the request
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= 16'(memf(int'(mem_addr)));
    end

    int n_chk = 0;
    int n_bad = 0;
    int m_pc = 0;
    int m_pos = 0;
    bit m_pend = 0;
    int m_due = 0;
    int m_iaddr = 0;
    int exp_map [8];
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_map(input int i, input int val);
        @(posedge clk); #1;
        step_valid = 1'b0;
        cfg_we     = 1'b1;
        cfg_wsel   = 3'(i);
        cfg_wdata  = 16'(val);
        exp_map[i] = val & 'hFFFF;
    endtask

    task automatic read_check(input int i);
        @(posedge clk); #1;
        cfg_we     = 1'b0;
        step_valid = 1'b0;
        cfg_rsel   = 3'(i);
        @(negedge clk);
        chk("R2 readback", int'(cfg_rdata), exp_map[i]);
    endtask

    task automatic do_cycle(input bit v, input bit a, input int m, input int o);
        int    s, b, mask, ea, raw;
        bit    exp_req, exp_rv;
        string lbl;
        @(posedge clk); #1;
        cfg_we     = 1'b0;
        step_valid = v;
        step_acc   = a;
        step_map   = 3'(m);
        step_ofs   = 16'(o);
        @(negedge clk);
        cyc++;
        chk("R6 step_pc", int'(step_pc), m_pc);
        chk("R6 sample_pos", int'(sample_pos), m_pos);
        exp_req = v && a && (m_pc % 3 == 0);
        chk("R5 mem_req", int'(mem_req), int'(exp_req));
        ea = 0;
        if (exp_req) begin
            s    = (exp_map[m] >> 8) & 7;
            b    = (exp_map[m] & 'hFF) << 10;
            mask = (1 << (10 + s)) - 1;
            raw  = b + ((o + m_pos) & mask);
            ea   = raw & 'h3FFFF;
            if (raw > 'h3FFFF || (b % (mask + 1)) != 0) lbl = "R4 mem_addr";
            else if ((exp_map[m] >> 11) != 0)           lbl = "R8 mem_addr";
            else                                        lbl = "R3 mem_addr";
            chk(lbl, int'(mem_addr), ea);
        end
        exp_rv = v && m_pend && (m_pc == m_due);
        chk("R7 rd_valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv) begin
            chk("R7 rd_data", int'(rd_data), memf(m_iaddr));
            m_pend = 0;
        end
        if (exp_req) begin
            m_pend  = 1;
            m_due   = m_pc + 2;
            m_iaddr = ea;
        end
        if (v) begin
            if (m_pc == 383) begin
                m_pc  = 0;
                m_pos = m_pos + 1;
            end else begin
                m_pc = m_pc + 1;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_map[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 step_pc", int'(step_pc), 0);
        chk("R1 sample_pos", int'(sample_pos), 0);
        chk("R1 mem_req", int'(mem_req), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        for (int i = 0; i < 8; i++) read_check(i);

        for (int p = 0; p < 12; p++) begin
            for (int i = 0; i < 8; i++) begin
                int s, o, t;
                s = (i + p) % 8;
                o = (p * 37 + i * 53 + 11) & 'hFF;
                t = (p % 2 == 1) ? ((i * 7 + p * 3) & 31) : 0;
                if (p == 0 && i == 7) begin s = 7; o = 'hFF; end
                if (p == 1 && i == 3) begin s = 6; o = 'hA0; end
                write_map(i, (t << 11) | (s << 8) | o);
            end
            for (int i = 0; i < 8; i++) read_check(i);
            for (int st = 0; st < 384; st++) begin
                int k, ofs, mp;
                bit acc;
                if (cyc % 7 == 3) do_cycle(1'b0, 1'b1, 0, 0);
                k = st / 3;
                if (st % 3 == 0) begin
                    case (k % 4)
                        0: ofs = 'hFFFF;
                        1: ofs = 0;
                        default: ofs = (k * 40503 + p * 4660) & 'hFFFF;
                    endcase
                    mp  = (k + p) % 8;
                    acc = (k % 5 != 4);
                end else begin
                    ofs = (st * 977) & 'hFFFF;
                    mp  = st % 8;
                    acc = 1'b1;
                end
                do_cycle(1'b1, acc, mp, ofs);
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule